// File: doc/BRIEF.md
# Variable-Page Unified Translation Buffer

This block is a fully associative translation buffer with 64 entries by default. Each entry holds a virtual page number, an 8-bit address-space identifier, a physical page number, nine flag bits and a page mask. The mask is derived from two size flags, so pages of 1 KB, 4 KB, 64 KB and 1 MB can sit side by side in the same array. A lookup compares the request against every entry at once. The result is registered and reports a single hit with its index, translated address and flags, a miss, or a multi-hit. A lookup runs in one of two modes: address-space matched, or page-number only.

Software fills the array through three kinds of entry write. An indexed tag write sets the page number, the identifier, the valid bit and the dirty bit. An indexed data write sets the physical page and the flags, and recomputes the mask. An associative write finds the entry that matches a page number and rewrites only its valid and dirty bits. Two register images also feed the array. The header register holds the current identifier. The control register holds a replacement counter, its wrap boundary and an instruction-side recency field. The counter advances on every lookup.

Top module: `utlb_core`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and both register images read 0.
- R2: In identifier mode (lk_use_asid=1), an entry hits only when its valid flag (bit 8) is set, its identifier equals header bits 7:0, and the request address agrees with the entry page number on every bit set in the entry mask. The result appears on the rs_* outputs one cycle after lk_req, with rs_valid high for exactly that cycle.
- R3: An entry whose share flag (bit 1) is set hits in identifier mode whatever its identifier.
- R4: In page-number mode (lk_use_asid=0), the identifier is not compared.
- R5: The size flags {bit 7, bit 4} select the mask: 00 gives 0xFFFFFC00, 01 gives 0xFFFFF000, 10 gives 0xFFFF0000, 11 gives 0xFFF00000. On a hit, rs_paddr = (ppn AND mask) OR (address AND NOT mask).
- R6: When more than one entry hits, rs_multi is 1, rs_hit is 0, and rs_idx, rs_paddr and rs_flags are 0.
- R7: An entry with its valid flag clear never hits, and a hit always reports flags with bit 8 set.
- R8: Each lookup moves the counter (control bits 15:10) to counter+1. The counter returns to 0 instead when that value equals the boundary (control bits 23:18) or equals 64. Without a lookup or a control write the counter holds.
- R9: A control write loads the counter from bits 15:10, the boundary from bits 23:18 and the recency field from bits 31:26. All other control bits read 0. When a control write and a lookup arrive in the same cycle, the written counter wins.
- R10: A header write stores the data ANDed with 0xFFFFFCFF. Header bits 7:0 are the current identifier.
- R11: An indexed data write (ent_op=1) stores ppn = data AND 0x1FFFFC00 and flags = data bits 8:0, and sets the entry mask from the new size flags.
- R12: An indexed tag write (ent_op=0) stores page number = data bits 31:10 and identifier = data bits 7:0. It copies data bit 8 into the valid flag and data bit 9 into the dirty flag (bit 2).
- R13: An associative write (ent_op=2) compares data bits 31:10, under the current identifier with the share flag honoured, against the valid entries. When exactly one entry matches, its valid flag takes data bit 8 and its dirty flag takes data bit 9. When no entry matches, nothing changes.
- R14: When an associative write matches more than one entry, assoc_multi is 1 for the next cycle only and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 32 | Lookup virtual address |
| lk_use_asid | input | 1 | 1 = identifier mode, 0 = page-number mode |
| rs_valid | output | 1 | Registered result strobe |
| rs_hit | output | 1 | Exactly one entry hit |
| rs_multi | output | 1 | More than one entry hit |
| rs_idx | output | IDX_W | Index of the hit entry |
| rs_paddr | output | 32 | Translated address |
| rs_flags | output | 9 | Flags of the hit entry |
| ent_we | input | 1 | Entry write strobe |
| ent_op | input | 2 | 0 tag, 1 data, 2 associative, 3 none |
| ent_idx | input | IDX_W | Entry index for indexed writes |
| ent_wdata | input | 32 | Entry write data |
| assoc_multi | output | 1 | Associative write found several matches |
| hdr_we | input | 1 | Header register write |
| hdr_wdata | input | 32 | Header write data |
| hdr_rdata | output | 32 | Header register image |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control register image |

## Verification
A corrupted entry field shows up only when a lookup selects that entry. A wrong page number or mask then turns a hit into a miss or a multi-hit, and a wrong physical page or flag shows up in rs_paddr or rs_flags on the cycle after that lookup. A wrong counter or boundary is visible in ctl_rdata on the cycle after the lookup that moves it. A reference model that compares every output on every cycle therefore catches a bad state at its first observable cycle. The stimulus revisits each written entry with lookups in both modes so that such errors are exposed.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int FLG_W   = 9;
    localparam int F_VALID = 8;
    localparam int F_DIRTY = 2;
    localparam int F_SHARE = 1;
    localparam int F_SZHI  = 7;
    localparam int F_SZLO  = 4;
    localparam int PG_LSB  = 10;
    localparam int VPG_W   = 32 - PG_LSB;
    localparam int PPG_W   = 29 - PG_LSB;
    localparam int ASID_W  = 8;

    typedef struct packed {
        logic [VPG_W-1:0]  vpn;
        logic [VPG_W-1:0]  msk;
        logic [ASID_W-1:0] asid;
        logic [PPG_W-1:0]  ppn;
        logic [FLG_W-1:0]  flg;
    } ent_t;

    typedef enum logic [1:0] {
        OP_TAG   = 2'd0,
        OP_DATA  = 2'd1,
        OP_ASSOC = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    // page mask over address bits 31:10 for the two size flags
    function automatic logic [VPG_W-1:0] size_mask(input logic [FLG_W-1:0] f);
        logic [VPG_W-1:0] m;
        case ({f[F_SZHI], f[F_SZLO]})
            2'b00:   m = 22'h3FFFFF;
            2'b01:   m = 22'h3FFFFC;
            2'b10:   m = 22'h3FFFC0;
            default: m = 22'h3FFC00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/utlb_match.sv
module utlb_match
    import utlb_pkg::*;
#(
    parameter int N_ENT = 64
) (
    input  ent_t [N_ENT-1:0]  ents,
    input  logic [VPG_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    input  logic              use_asid,
    output logic [N_ENT-1:0]  hit
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic id_ok;
        logic pg_ok;
        assign id_ok  = !use_asid || ents[g].flg[F_SHARE] || (ents[g].asid == asid);
        assign pg_ok  = ((vpn ^ ents[g].vpn) & ents[g].msk) == '0;
        assign hit[g] = ents[g].flg[F_VALID] && id_ok && pg_ok;
    end

endmodule

// File: rtl/utlb_enc.sv
module utlb_enc #(
    parameter int N_ENT = 64,
    parameter int IDX_W = 6
) (
    input  logic [N_ENT-1:0] hit,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             multi
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i]) idx = IDX_W'(i);
        end
        any   = |hit;
        multi = |(hit & (hit - N_ENT'(1)));
    end

endmodule

// File: rtl/utlb_core.sv
module utlb_core
    import utlb_pkg::*;
#(
    parameter  int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [31:0]      lk_vpn,
    input  logic             lk_use_asid,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic             rs_multi,
    output logic [IDX_W-1:0] rs_idx,
    output logic [31:0]      rs_paddr,
    output logic [8:0]       rs_flags,
    input  logic             ent_we,
    input  logic [1:0]       ent_op,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic [31:0]      ent_wdata,
    output logic             assoc_multi,
    input  logic             hdr_we,
    input  logic [31:0]      hdr_wdata,
    output logic [31:0]      hdr_rdata,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_wdata,
    output logic [31:0]      ctl_rdata
);

    localparam int CNT_LSB = 10;
    localparam int BND_LSB = 18;
    localparam int REC_LSB = 26;
    localparam int REC_W   = 6;

    typedef struct packed {
        ent_t [N_ENT-1:0] ent;
        logic [31:0]      hdr;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] bnd;
        logic [REC_W-1:0] rec;
        logic             rs_valid;
        logic             rs_hit;
        logic             rs_multi;
        logic [IDX_W-1:0] rs_idx;
        logic [31:0]      rs_paddr;
        logic [FLG_W-1:0] rs_flags;
        logic             amulti;
    } st_t;

    st_t s_d, s_q;

    logic [N_ENT-1:0] lk_hit, as_hit;
    logic [IDX_W-1:0] lk_idx, as_idx;
    logic             lk_any, lk_multi, as_any, as_multi;

    utlb_match #(.N_ENT(N_ENT)) i_lk_match (
        .ents(s_q.ent), .vpn(lk_vpn[31:PG_LSB]), .asid(s_q.hdr[ASID_W-1:0]),
        .use_asid(lk_use_asid), .hit(lk_hit)
    );

    utlb_match #(.N_ENT(N_ENT)) i_as_match (
        .ents(s_q.ent), .vpn(ent_wdata[31:PG_LSB]), .asid(s_q.hdr[ASID_W-1:0]),
        .use_asid(1'b1), .hit(as_hit)
    );

    utlb_enc #(.N_ENT(N_ENT), .IDX_W(IDX_W)) i_lk_enc (
        .hit(lk_hit), .idx(lk_idx), .any(lk_any), .multi(lk_multi)
    );

    utlb_enc #(.N_ENT(N_ENT), .IDX_W(IDX_W)) i_as_enc (
        .hit(as_hit), .idx(as_idx), .any(as_any), .multi(as_multi)
    );

    ent_t             sel;
    logic             one_hit;
    logic [31:0]      full_msk;
    logic [IDX_W:0]   cnt_nxt;
    op_e              op;
    logic             ctl_unused;

    assign op         = op_e'(ent_op);
    assign ctl_unused = ^{ctl_wdata[CNT_LSB-1:0], ctl_wdata[BND_LSB-1:CNT_LSB+IDX_W],
                          ctl_wdata[REC_LSB-1:BND_LSB+IDX_W]};

    always_comb begin
        s_d        = s_q;
        s_d.amulti = 1'b0;

        // lookup result
        sel      = s_q.ent[lk_idx];
        one_hit  = lk_req && lk_any && !lk_multi;
        full_msk = {sel.msk, {PG_LSB{1'b0}}};
        s_d.rs_valid = lk_req;
        s_d.rs_hit   = one_hit;
        s_d.rs_multi = lk_req && lk_multi;
        s_d.rs_idx   = one_hit ? lk_idx : '0;
        s_d.rs_flags = one_hit ? sel.flg : '0;
        s_d.rs_paddr = one_hit
            ? (({3'b000, sel.ppn, {PG_LSB{1'b0}}} & full_msk) | (lk_vpn & ~full_msk))
            : 32'h0;

        // replacement counter
        cnt_nxt = {1'b0, s_q.cnt} + (IDX_W+1)'(1);
        if (lk_req) begin
            if (cnt_nxt[IDX_W-1:0] == s_q.bnd || cnt_nxt == (IDX_W+1)'(N_ENT))
                s_d.cnt = '0;
            else
                s_d.cnt = cnt_nxt[IDX_W-1:0];
        end
        if (ctl_we) begin
            s_d.cnt = ctl_wdata[CNT_LSB +: IDX_W];
            s_d.bnd = ctl_wdata[BND_LSB +: IDX_W];
            s_d.rec = ctl_wdata[REC_LSB +: REC_W];
        end

        if (hdr_we) s_d.hdr = hdr_wdata & 32'hFFFFFCFF;

        // entry writes
        if (ent_we) begin
            case (op)
                OP_TAG: begin
                    s_d.ent[ent_idx].vpn          = ent_wdata[31:PG_LSB];
                    s_d.ent[ent_idx].asid         = ent_wdata[ASID_W-1:0];
                    s_d.ent[ent_idx].flg[F_VALID] = ent_wdata[8];
                    s_d.ent[ent_idx].flg[F_DIRTY] = ent_wdata[9];
                end
                OP_DATA: begin
                    s_d.ent[ent_idx].ppn = ent_wdata[28:PG_LSB];
                    s_d.ent[ent_idx].flg = ent_wdata[FLG_W-1:0];
                    s_d.ent[ent_idx].msk = size_mask(ent_wdata[FLG_W-1:0]);
                end
                OP_ASSOC: begin
                    if (as_multi) begin
                        s_d.amulti = 1'b1;
                    end else if (as_any) begin
                        s_d.ent[as_idx].flg[F_VALID] = ent_wdata[8];
                        s_d.ent[as_idx].flg[F_DIRTY] = ent_wdata[9];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < N_ENT; i++) s_q.ent[i].msk <= size_mask('0);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl_rdata                     = '0;
        ctl_rdata[CNT_LSB +: IDX_W]   = s_q.cnt;
        ctl_rdata[BND_LSB +: IDX_W]   = s_q.bnd;
        ctl_rdata[REC_LSB +: REC_W]   = s_q.rec;
    end

    assign hdr_rdata   = s_q.hdr;
    assign rs_valid    = s_q.rs_valid;
    assign rs_hit      = s_q.rs_hit;
    assign rs_multi    = s_q.rs_multi;
    assign rs_idx      = s_q.rs_idx;
    assign rs_paddr    = s_q.rs_paddr;
    assign rs_flags    = s_q.rs_flags;
    assign assoc_multi = s_q.amulti;

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
    parameter int IDX_W = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_req,
    input logic        rs_valid,
    input logic        rs_hit,
    input logic        rs_multi,
    input logic [8:0]  rs_flags,
    input logic        ent_we,
    input logic [1:0]  ent_op,
    input logic        assoc_multi,
    input logic        hdr_we,
    input logic [31:0] hdr_wdata,
    input logic [31:0] hdr_rdata,
    input logic        ctl_we,
    input logic [31:0] ctl_rdata
);

    AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rs_valid); // R2

    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rs_valid); // R2

    AST_HIT_XOR_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> !rs_multi); // R6

    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> rs_flags[8]); // R7

    AST_COUNTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !ctl_we) |=>
            (ctl_rdata[10 +: IDX_W] == IDX_W'($past(ctl_rdata[10 +: IDX_W]) + 1'b1)) ||
            (ctl_rdata[10 +: IDX_W] == '0)); // R8

    AST_COUNTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_req && !ctl_we) |=> $stable(ctl_rdata[10 +: IDX_W])); // R8

    AST_HEADER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |=> hdr_rdata == ($past(hdr_wdata) & 32'hFFFFFCFF)); // R10

    AST_ASSOC_MULTI_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        assoc_multi |-> $past(ent_we && ent_op == 2'd2)); // R14

endmodule

bind utlb_core utlb_chk #(.IDX_W(IDX_W)) i_utlb_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_multi(rs_multi), .rs_flags(rs_flags),
    .ent_we(ent_we), .ent_op(ent_op), .assoc_multi(assoc_multi),
    .hdr_we(hdr_we), .hdr_wdata(hdr_wdata), .hdr_rdata(hdr_rdata),
    .ctl_we(ctl_we), .ctl_rdata(ctl_rdata)
);

// File: tb/test_utlb_core.sv
module test_utlb_core;

    localparam int N = 64;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_req = 1'b0;
    logic [31:0]   lk_vpn = '0;
    logic          lk_use_asid = 1'b0;
    logic          rs_valid, rs_hit, rs_multi, assoc_multi;
    logic [IW-1:0] rs_idx;
    logic [31:0]   rs_paddr, hdr_rdata, ctl_rdata;
    logic [8:0]    rs_flags;
    logic          ent_we = 1'b0;
    logic [1:0]    ent_op = 2'd3;
    logic [IW-1:0] ent_idx = '0;
    logic [31:0]   ent_wdata = '0;
    logic          hdr_we = 1'b0;
    logic [31:0]   hdr_wdata = '0;
    logic          ctl_we = 1'b0;
    logic [31:0]   ctl_wdata = '0;

    always #4 clk = ~clk;

    utlb_core i_utlb_core (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit [31:0] m_vpn [N];
    bit [31:0] m_msk [N];
    bit [31:0] m_ppn [N];
    bit [7:0]  m_asid[N];
    bit [8:0]  m_flg [N];
    int        m_cnt, m_bnd, m_rec;
    bit [31:0] m_hdr;

    bit        e_valid, e_hit, e_multi, e_am;
    int        e_idx;
    bit [31:0] e_paddr;
    bit [8:0]  e_flags;

    function automatic bit [31:0] mask_for(bit [8:0] f);
        if (f[7] && f[4]) return 32'hFFF00000;
        if (f[7])         return 32'hFFFF0000;
        if (f[4])         return 32'hFFFFF000;
        return 32'hFFFFFC00;
    endfunction

    function automatic bit hits(int i, bit [31:0] a, bit use_id, bit [7:0] id);
        if (!m_flg[i][8]) return 1'b0;
        if (use_id && !m_flg[i][1] && m_asid[i] != id) return 1'b0;
        return ((a ^ m_vpn[i]) & m_msk[i]) == 0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = 0; m_msk[i] = 32'hFFFFFC00; m_ppn[i] = 0; m_asid[i] = 0; m_flg[i] = 0;
        end
        m_cnt = 0; m_bnd = 0; m_rec = 0; m_hdr = 0;
    endtask

    task automatic compare(string tag);
        chk(tag, "rs_valid", 32'(rs_valid), 32'(e_valid));
        chk(tag, "rs_hit", 32'(rs_hit), 32'(e_hit));
        chk(tag, "rs_multi", 32'(rs_multi), 32'(e_multi));
        chk(tag, "rs_idx", 32'(rs_idx), 32'(e_idx));
        chk(tag, "rs_paddr", rs_paddr, e_paddr);
        chk(tag, "rs_flags", 32'(rs_flags), 32'(e_flags));
        chk(tag, "assoc_multi", 32'(assoc_multi), 32'(e_am));
        chk(tag, "hdr_rdata", hdr_rdata, m_hdr);
        chk(tag, "ctl_rdata", ctl_rdata,
            (32'(m_rec) << 26) | (32'(m_bnd) << 18) | (32'(m_cnt) << 10));
    endtask

    // inputs are already driven; compute the model, clock once, compare
    task automatic step(string tag);
        int cnt = 0, id = 0, acnt = 0, aid = 0;
        for (int i = 0; i < N; i++) begin
            if (hits(i, lk_vpn, lk_use_asid, m_hdr[7:0])) begin cnt++; id = i; end
            if (hits(i, ent_wdata, 1'b1, m_hdr[7:0])) begin acnt++; aid = i; end
        end
        e_valid = lk_req;
        e_hit   = lk_req && cnt == 1;
        e_multi = lk_req && cnt > 1;
        e_idx   = e_hit ? id : 0;
        e_flags = e_hit ? m_flg[id] : 9'h0;
        e_paddr = e_hit ? ((m_ppn[id] & m_msk[id]) | (lk_vpn & ~m_msk[id])) : 32'h0;
        e_am    = ent_we && ent_op == 2'd2 && acnt > 1;
        if (lk_req) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == m_bnd || m_cnt == 64) m_cnt = 0;
        end
        if (ctl_we) begin
            m_cnt = (ctl_wdata >> 10) & 63; m_bnd = (ctl_wdata >> 18) & 63; m_rec = (ctl_wdata >> 26) & 63;
        end
        if (hdr_we) m_hdr = hdr_wdata & 32'hFFFFFCFF;
        if (ent_we) begin
            case (ent_op)
                2'd0: begin
                    m_vpn[ent_idx] = ent_wdata & 32'hFFFFFC00;
                    m_asid[ent_idx] = ent_wdata[7:0];
                    m_flg[ent_idx][8] = ent_wdata[8];
                    m_flg[ent_idx][2] = ent_wdata[9];
                end
                2'd1: begin
                    m_ppn[ent_idx] = ent_wdata & 32'h1FFFFC00;
                    m_flg[ent_idx] = ent_wdata[8:0];
                    m_msk[ent_idx] = mask_for(ent_wdata[8:0]);
                end
                2'd2: if (acnt == 1) begin
                    m_flg[aid][8] = ent_wdata[8];
                    m_flg[aid][2] = ent_wdata[9];
                end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        lk_req = 0; ent_we = 0; ent_op = 2'd3; hdr_we = 0; ctl_we = 0;
        compare(tag);
    endtask

    task automatic look(bit [31:0] a, bit use_id, string tag);
        lk_req = 1; lk_vpn = a; lk_use_asid = use_id; step(tag);
    endtask
    task automatic ewr(bit [1:0] op, int idx, bit [31:0] d, string tag);
        ent_we = 1; ent_op = op; ent_idx = IW'(idx); ent_wdata = d; step(tag);
    endtask
    task automatic hwr(bit [31:0] d, string tag);
        hdr_we = 1; hdr_wdata = d; step(tag);
    endtask
    task automatic cwr(bit [31:0] d, string tag);
        ctl_we = 1; ctl_wdata = d; step(tag);
    endtask

    initial begin
        reset_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_valid = 0; e_hit = 0; e_multi = 0; e_idx = 0; e_paddr = 0; e_flags = 0; e_am = 0;
        compare("R1");
        look(32'h00400123, 1, "R1");
        look(32'h00000000, 0, "R1");

        hwr(32'h12345B7F, "R10");                       // identifier 0x7F
        ewr(2'd0, 3, 32'h0040017F, "R12");
        ewr(2'd1, 3, 32'hEC000100, "R11");              // upper bits dropped
        look(32'h00400123, 1, "R2");
        hwr(32'h00000010, "R10");
        look(32'h00400123, 1, "R2");                    // identifier differs: miss
        look(32'h00400123, 0, "R4");

        ewr(2'd0, 5, 32'h00800122, "R12");
        ewr(2'd1, 5, 32'h10000112, "R11");              // share + 4 KB
        look(32'h00800ABC, 1, "R3");

        ewr(2'd0, 7, 32'h01000110, "R12");
        ewr(2'd1, 7, 32'h02000180, "R5");               // 64 KB
        look(32'h0100BEEF, 1, "R5");
        ewr(2'd0, 9, 32'h03000110, "R12");
        ewr(2'd1, 9, 32'h05000190, "R5");               // 1 MB
        look(32'h030ABCDE, 1, "R5");
        look(32'h00400400, 0, "R5");                    // outside the 1 KB page

        ewr(2'd0, 11, 32'h00400110, "R12");
        ewr(2'd1, 11, 32'h0D000100, "R11");
        look(32'h00400010, 1, "R2");
        look(32'h00400010, 0, "R6");                    // entries 3 and 11

        ewr(2'd0, 13, 32'h06000010, "R7");              // valid clear
        ewr(2'd1, 13, 32'h06000000, "R7");
        look(32'h06000000, 0, "R7");

        cwr(32'h00140800 | 32'h00000301 | (32'd9 << 26), "R9");
        for (int k = 0; k < 4; k++) look(32'h00400123, 0, "R8");
        cwr(32'h0000F800, "R9");                        // counter 62, boundary 0
        look(32'h0, 0, "R8");
        look(32'h0, 0, "R8");
        look(32'h0, 0, "R8");
        lk_req = 1; lk_vpn = 32'h0; ctl_we = 1; ctl_wdata = 32'h00000C00; step("R9");

        ewr(2'd2, 0, 32'h01000300, "R13");              // dirty on entry 7
        look(32'h01001234, 1, "R13");
        ewr(2'd2, 0, 32'h7F000300, "R13");              // no match
        look(32'h030ABCDE, 1, "R13");
        ewr(2'd2, 0, 32'h01000000, "R13");              // invalidate entry 7
        look(32'h01001234, 1, "R13");
        ewr(2'd0, 20, 32'h00000310, "R12");             // tag write with dirty
        ewr(2'd1, 20, 32'h00000104, "R11");
        look(32'h00000044, 1, "R12");

        ewr(2'd0, 15, 32'h00800110, "R14");
        ewr(2'd1, 15, 32'h0E000100, "R14");
        ewr(2'd2, 0, 32'h00800000, "R14");              // entries 5 and 15
        look(32'h00800000, 1, "R14");                   // both still valid
        step("R14");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule